// File: doc/BRIEF.md
# Display Serial Packet Assembler

This block turns packet requests into the byte stream that a display serial link's lane layer consumes. A request names a data identifier and a 16-bit word, and says whether the packet is short or long. For a short packet the word holds two data bytes. For a long packet the word is the payload length in bytes, and the payload arrives on a separate byte stream.

The assembler adds a Hamming-style error-correction byte to the 24-bit header. For long packets it also appends a 16-bit CRC computed over the payload. The output is a valid/ready byte stream whose last-byte flag marks the end of each packet. Payload bytes pass straight through to the output with no buffering. If the producer's end-of-payload flag disagrees with the declared length, the block raises an error pulse.

Top module: `pkt_assembler`

## Requirements
- R1: After reset `out_valid`, `out_last` and `len_err` are 0 and `req_ready` is 1.
- R2: A short request produces exactly 4 output bytes in this order: identifier, `req_word[7:0]`, `req_word[15:8]`, ECC. `out_last` is 1 only on the ECC byte.
- R3: ECC bit k (k = 0..5) is the XOR of the header bits selected by mask k. The header is {word, identifier}, with the identifier in bits 7:0. The masks are 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0 and 0xEFFC00. ECC bits 7:6 are always 0.
- R4: A long request starts with the same 4-byte header, in which the word is the length, sent low byte first. `out_last` stays 0 on every header byte.
- R5: After the header, exactly `req_word` payload bytes pass unchanged and in order from `pl_data` to `out_data`. `out_last` is 0 on each of them.
- R6: Two CRC bytes follow the payload, low byte first, and `out_last` is 1 on the high byte. The CRC uses polynomial 0x1021 with seed 0xFFFF and no final XOR, and each byte is fed least significant bit first. An empty payload gives 0xFF 0xFF, for a 6-byte packet.
- R7: `len_err` is 1 for one cycle, in the cycle after a payload byte transfer whose `pl_last` differs from "this is byte number `req_word`". Otherwise `len_err` is 0. In every case the block takes exactly `req_word` payload bytes.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` and `out_data` unchanged.
- R9: `req_ready` is 1 only between packets. It falls after a request is accepted and returns in the cycle after the last byte transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_long | input | 1 | 1 = long packet, 0 = short packet |
| req_di | input | 8 | Data identifier byte |
| req_word | input | 16 | Two data bytes (short) or payload length (long) |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | Producer's end-of-payload flag |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |
| len_err | output | 1 | Payload length mismatch pulse |

## Verification
The hold check on `out_data` during payload assumes the producer keeps `pl_valid` and `pl_data` steady until `pl_ready`. The bench keeps to this by re-presenting a refused byte unchanged. The error-cause check assumes that `pl_last` matters only when a payload transfer happens. The bench feeds random payloads of random length, applies random stalls on both streams, and deliberately asserts `pl_last` early or leaves it off. The expected bytes come from the bench's own ECC and CRC functions. The CRC function uses a non-reflected formulation.

// File: rtl/pkt_asm_pkg.sv
package pkt_asm_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int HDR_W   = BYTE_W + WORD_W;
    localparam int ECC_W   = 6;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_PAY  = 2'd2,
        PH_TRL  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e               ph;
        logic [1:0]           idx;
        logic                 lng;
        logic [BYTE_W-1:0]    di;
        logic [WORD_W-1:0]    word;
        logic [WORD_W-1:0]    left;
        logic [WORD_W-1:0]    crc;
        logic                 err;
    } asm_regs_t;
endpackage

// File: rtl/pkt_hdr_ecc.sv
module pkt_hdr_ecc
    import pkt_asm_pkg::*;
(
    input  logic [HDR_W-1:0]  hdr,
    output logic [BYTE_W-1:0] ecc
);
    function automatic logic [HDR_W-1:0] sel_mask(input int k);
        case (k)
            0:       sel_mask = 24'hF12CB7;
            1:       sel_mask = 24'hF2555B;
            2:       sel_mask = 24'h749A6D;
            3:       sel_mask = 24'hB8E38E;
            4:       sel_mask = 24'hDF03F0;
            default: sel_mask = 24'hEFFC00;
        endcase
    endfunction

    for (genvar k = 0; k < ECC_W; k++) begin : g_par
        assign ecc[k] = ^(hdr & sel_mask(k));
    end
    assign ecc[BYTE_W-1:ECC_W] = '0;
endmodule

// File: rtl/pkt_crc_step.sv
module pkt_crc_step
    import pkt_asm_pkg::*;
#(
    parameter logic [WORD_W-1:0] POLY = 16'h1021
) (
    input  logic [WORD_W-1:0] crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [WORD_W-1:0] crc_out
);
    localparam logic [WORD_W-1:0] RPOLY = reverse_poly(POLY);

    function automatic logic [WORD_W-1:0] reverse_poly(input logic [WORD_W-1:0] p);
        for (int i = 0; i < WORD_W; i++) reverse_poly[i] = p[WORD_W-1-i];
    endfunction

    always_comb begin
        logic [WORD_W-1:0] c;
        logic fb;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ data_in[i];
            c  = c >> 1;
            if (fb) c = c ^ RPOLY;
        end
        crc_out = c;
    end
endmodule

// File: rtl/pkt_assembler.sv
module pkt_assembler
    import pkt_asm_pkg::*;
#(
    parameter logic [WORD_W-1:0] CRC_SEED = 16'hFFFF,
    parameter logic [WORD_W-1:0] CRC_POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_long,
    input  logic [BYTE_W-1:0] req_di,
    input  logic [WORD_W-1:0] req_word,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [BYTE_W-1:0] pl_data,
    input  logic              pl_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              len_err
);
    localparam asm_regs_t REGS_RST = '{ph: PH_IDLE, idx: 2'd0, lng: 1'b0, di: '0,
                                       word: '0, left: '0, crc: '0, err: 1'b0};
    localparam logic [1:0] ECC_IDX = 2'd3;

    asm_regs_t r_q, r_d;
    logic [BYTE_W-1:0] ecc_w;
    logic [WORD_W-1:0] crc_nx;

    pkt_hdr_ecc u_ecc (
        .hdr ({r_q.word, r_q.di}),
        .ecc (ecc_w)
    );

    pkt_crc_step #(.POLY(CRC_POLY)) u_crc (
        .crc_in  (r_q.crc),
        .data_in (pl_data),
        .crc_out (crc_nx)
    );

    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        req_ready = 1'b0;
        pl_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        case (r_q.ph)
            PH_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.ph   = PH_HDR;
                    r_d.idx  = 2'd0;
                    r_d.lng  = req_long;
                    r_d.di   = req_di;
                    r_d.word = req_word;
                    r_d.left = req_word;
                    r_d.crc  = CRC_SEED;
                end
            end
            PH_HDR: begin
                out_valid = 1'b1;
                case (r_q.idx)
                    2'd0:    out_data = r_q.di;
                    2'd1:    out_data = r_q.word[BYTE_W-1:0];
                    2'd2:    out_data = r_q.word[WORD_W-1:BYTE_W];
                    default: out_data = ecc_w;
                endcase
                out_last = (r_q.idx == ECC_IDX) && !r_q.lng;
                if (out_ready) begin
                    if (r_q.idx == ECC_IDX) begin
                        r_d.idx = 2'd0;
                        if (!r_q.lng)           r_d.ph = PH_IDLE;
                        else if (r_q.word == '0) r_d.ph = PH_TRL;
                        else                    r_d.ph = PH_PAY;
                    end else begin
                        r_d.idx = r_q.idx + 2'd1;
                    end
                end
            end
            PH_PAY: begin
                out_valid = pl_valid;
                out_data  = pl_data;
                pl_ready  = out_ready;
                if (pl_valid && out_ready) begin
                    r_d.crc  = crc_nx;
                    r_d.left = r_q.left - 1'b1;
                    r_d.err  = pl_last != (r_q.left == 16'd1);
                    if (r_q.left == 16'd1) r_d.ph = PH_TRL;
                end
            end
            default: begin
                out_valid = 1'b1;
                out_data  = r_q.idx[0] ? r_q.crc[WORD_W-1:BYTE_W] : r_q.crc[BYTE_W-1:0];
                out_last  = r_q.idx[0];
                if (out_ready) begin
                    if (r_q.idx[0]) begin
                        r_d.ph  = PH_IDLE;
                        r_d.idx = 2'd0;
                    end else begin
                        r_d.idx = 2'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign len_err = r_q.err;

    a_r2_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && r_q.ph != PH_PAY) |=> (out_valid && $stable(out_data)));

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> req_ready);

    a_r5_payload_not_last: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && pl_ready) |-> !out_last);

    a_r7_err_needs_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> $past(pl_valid && pl_ready));

    a_r3_ecc_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && r_q.ph == PH_HDR && r_q.idx == ECC_IDX) |-> (out_data[7:6] == 2'b00));
endmodule

// File: tb/sim_pkt_assembler.sv
module sim_pkt_assembler;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_long = 1'b0;
    logic [7:0]  req_di = '0;
    logic [15:0] req_word = '0;
    logic        pl_valid = 1'b0, pl_last = 1'b0, out_ready = 1'b0;
    logic [7:0]  pl_data = '0;
    logic        req_ready, pl_ready, out_valid, out_last, len_err;
    logic [7:0]  out_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_assembler u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_long(req_long),
        .req_di(req_di), .req_word(req_word),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .len_err(len_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ecc_ref(input logic [23:0] h);
        logic [23:0] m [6];
        logic [7:0] e;
        m[0] = 24'hF12CB7; m[1] = 24'hF2555B; m[2] = 24'h749A6D;
        m[3] = 24'hB8E38E; m[4] = 24'hDF03F0; m[5] = 24'hEFFC00;
        e = '0;
        for (int b = 0; b < 24; b++)
            for (int k = 0; k < 6; k++)
                if (h[b] && m[k][b]) e[k] = ~e[k];
        return e;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    function automatic logic [15:0] crc_ref(input logic [7:0] d [$]);
        logic [15:0] c;
        logic [15:0] r;
        c = 16'hFFFF;
        foreach (d[n]) begin
            c = c ^ {rev8(d[n]), 8'h00};
            for (int i = 0; i < 8; i++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        for (int i = 0; i < 16; i++) r[i] = c[15-i];
        return r;
    endfunction

    // mode 0: correct pl_last, 1: pl_last on first byte, 2: pl_last never set
    task automatic run_pkt(input bit lng, input logic [7:0] di, input logic [15:0] word, input int mode);
        logic [7:0] pay [$];
        logic [7:0] exp [$];
        logic [15:0] crc;
        logic [7:0] prev_data;
        bit accepted, done, held, stall, exp_err, hs_req, hs_out, hs_pl;
        int got, pi, npay;
        npay = lng ? int'(word) : 0;
        for (int i = 0; i < npay; i++) pay.push_back(8'($urandom));
        exp.push_back(di);
        exp.push_back(word[7:0]);
        exp.push_back(word[15:8]);
        exp.push_back(ecc_ref({word, di}));
        if (lng) begin
            foreach (pay[i]) exp.push_back(pay[i]);
            crc = crc_ref(pay);
            exp.push_back(crc[7:0]);
            exp.push_back(crc[15:8]);
        end
        accepted = 0; done = 0; held = 0; stall = 0; exp_err = 0;
        got = 0; pi = 0; prev_data = '0;
        while (!done) begin
            @(negedge clk);
            if (!accepted) begin
                req_valid = 1'b1; req_long = lng; req_di = di; req_word = word;
            end else begin
                req_valid = 1'b0;
            end
            if (!held) begin
                if (pi < npay) begin
                    pl_valid = ($urandom % 4) != 0;
                    pl_data  = pay[pi];
                    pl_last  = (mode == 0) ? (pi == npay - 1) : (mode == 1) ? (pi == 0) : 1'b0;
                end else begin
                    pl_valid = 1'b0; pl_last = 1'b0;
                end
            end
            out_ready = ($urandom % 3) != 0;
            #1;
            chk(len_err == exp_err, "R7 len_err", 32'(len_err), 32'(exp_err));
            if (stall) chk(out_valid && out_data == prev_data, "R8 hold under stall",
                           {23'd0, out_valid, out_data}, {23'd0, 1'b1, prev_data});
            if (accepted) chk(!req_ready, "R9 busy during packet", 32'(req_ready), 32'd0);
            hs_req = req_valid && req_ready;
            hs_out = out_valid && out_ready;
            hs_pl  = pl_valid && pl_ready;
            if (hs_out) begin
                if (got < exp.size()) begin
                    chk(out_data == exp[got], lng ? "R4/R5/R6 long byte" : "R2 short byte",
                        32'(out_data), 32'(exp[got]));
                    if (got == 3) chk(out_data[7:6] == 2'b00, "R3 ecc top bits", 32'(out_data[7:6]), 32'd0);
                end else begin
                    chk(1'b0, "R5 extra byte", 32'(got), 32'(exp.size()));
                end
                chk(out_last == (got == exp.size() - 1), lng ? "R6 last flag" : "R2 last flag",
                    32'(out_last), 32'(got == exp.size() - 1));
                got++;
                if (out_last) done = 1;
            end
            exp_err = hs_pl ? (pl_last != (pi == npay - 1)) : 1'b0;
            if (hs_pl) begin pi++; held = 0; end
            else held = pl_valid;
            stall = out_valid && !out_ready;
            prev_data = out_data;
            if (hs_req) accepted = 1;
        end
        chk(got == exp.size(), "R2/R6 packet length", 32'(got), 32'(exp.size()));
        chk(pi == npay, "R7 payload bytes taken", 32'(pi), 32'(npay));
        @(negedge clk);
        req_valid = 1'b0; pl_valid = 1'b0; out_ready = 1'b0;
        #1;
        chk(req_ready, "R9 ready after last", 32'(req_ready), 32'd1);
        chk(!len_err, "R7 no late error", 32'(len_err), 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid && !out_last, "R1 reset outputs", {30'd0, out_valid, out_last}, 32'd0);
        chk(req_ready, "R1 reset ready", 32'(req_ready), 32'd1);
        chk(!len_err, "R1 reset error", 32'(len_err), 32'd0);
        run_pkt(1'b0, 8'h05, 16'hA511, 0);   // R2 short
        run_pkt(1'b0, 8'hFF, 16'hFFFF, 0);   // R3 all ones header
        run_pkt(1'b1, 8'h39, 16'd0, 0);      // R6 empty payload
        run_pkt(1'b1, 8'h29, 16'd1, 0);      // R5 single byte
        run_pkt(1'b1, 8'h39, 16'd4, 1);      // R7 early last
        run_pkt(1'b1, 8'h29, 16'd5, 2);      // R7 missing last
        run_pkt(1'b1, 8'h39, 16'd300, 0);    // R4 high length byte non-zero
        for (int n = 0; n < 30; n++) begin
            int m;
            m = ($urandom % 5 == 0) ? int'(1 + $urandom % 2) : 0;
            run_pkt(1'($urandom), 8'($urandom), 16'($urandom % 41), m);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule